// File: doc/BRIEF.md
# Rank Refresh Sequencer

This block runs the refresh for one memory rank. A free-running cycle count acts as its time base. When the refresh timer fires, the block takes the rank out of service. It waits for accesses already in flight to finish. If the rank is in power-down, it asks for a wake-up. It then closes any open banks with a single precharge-all. Once the rank is quiet it issues a refresh command and keeps the rank out of service for the refresh recovery time. At that point it arms the timer for the next refresh.

An absolute due time is kept for each refresh and moved forward by the refresh interval when the command goes out. The next timer shot is placed one precharge time before that due time, so the precharge delay is absorbed. A refresh issued so late that the next one could no longer be met sets a sticky overrun flag. The block also restarts refresh after self-refresh exit, holds off re-arming while the rank is entering self-refresh, and responds to a system drain. During a drain it keeps the rank awake after refresh and asks for any self-refreshing rank to be woken.

The power-state choices and the request scheduler sit outside this block. They talk to it through the level and pulse signals listed below.

Top module: `rfsh_seq`

## Requirements
- R1: After reset, rank_avail is 1, and ref_pending, pre_all, ref_cmd, wake_req, relow_req and overrun are all 0. The first refresh timer shot happens when the cycle count reaches T_REFI - T_RP.
- R2: When the timer fires while the sequencer is idle, the sequencer records the current cycle count as the due time. ref_pending goes high on the next cycle. The next shot is placed at the recorded due time plus T_REFI minus T_RP. With no hold-offs, ref_cmd is high exactly 3 cycles after ref_pending rises.
- R3: rank_avail is 0 in every sequencer state other than idle. ref_pending stays high from the drain wait through the end of the refresh, and it stays low during the self-refresh recovery wait.
- R4: While drain_done is 0 the sequencer waits and issues no refresh. If drain_done is 1 in cycle D, ref_cmd is high in cycle D+3, provided nothing else holds it off.
- R5: If banks_open is non-zero when the precharge step is reached, pre_all pulses for exactly one cycle, however long the banks stay open. ref_cmd is held back until banks_open is 0, pwr_idle is 1 and act_pending is 0. If these become true in cycle D, ref_cmd is high in cycle D+1.
- R6: In the wake step, a rank with pwr_low = 1 sees wake_req held high until wake_ack. If wake_ack arrives in cycle D, ref_cmd is issued in cycle D+2+T_XP, which adds a delay of T_XP.
- R7: When ref_cmd is issued in cycle N with recorded due time U, overrun is set if U + T_REFI < N + T_RFC. Once set, it stays set until reset.
- R8: After ref_cmd in cycle N, rank_avail returns to 1 in cycle N + T_RFC + 1.
- R9: If the rank was woken for the refresh, relow_req pulses in cycle N + T_RFC, where N is the ref_cmd cycle, unless sys_drain is 1. In that case no pulse is produced.
- R10: If sref_entering is 1 in the last refresh cycle, the timer is not re-armed. The rank then stays available with no new refresh until a self-refresh exit.
- R11: If sref_exit is 1 in idle cycle D, rank_avail is 0 from cycle D+1, and ref_pending rises in cycle D+1+T_XS, which starts a refresh.
- R12: sref_wake equals sys_drain AND in_sref.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drain_done | input | 1 | Accesses in flight to the rank have finished |
| banks_open | input | BANK_W | Number of open banks in the rank |
| act_pending | input | 1 | An activate is scheduled for the rank |
| pwr_idle | input | 1 | Power controller reports the rank idle with all banks closed |
| pwr_low | input | 1 | Rank is in a power-down state |
| wake_ack | input | 1 | Power controller accepted the wake-up |
| sref_entering | input | 1 | Rank is moving into self-refresh after this refresh |
| sref_exit | input | 1 | Pulse: rank has left self-refresh |
| in_sref | input | 1 | Rank is currently in self-refresh |
| sys_drain | input | 1 | System drain request |
| pre_all | output | 1 | Precharge-all command pulse |
| ref_cmd | output | 1 | Refresh command pulse |
| rank_avail | output | 1 | Rank may accept requests |
| ref_pending | output | 1 | Refresh in progress; low-power entry is blocked |
| wake_req | output | 1 | Request to leave power-down for refresh |
| relow_req | output | 1 | Pulse: return the rank to low power after refresh |
| sref_wake | output | 1 | Force the rank out of self-refresh for a drain |
| overrun | output | 1 | Sticky flag: refresh issued too late to keep up |

## Verification
The checks on the command outputs assume that banks_open stays 0 from the moment the precharge step lets the refresh start until the refresh completes. They also assume that wake_ack is only raised while wake_req is high. The bench changes banks_open, pwr_idle and act_pending only while the sequencer is idle or still waiting in the precharge step. It raises wake_ack only after it has seen wake_req. It drives every input a quarter period after the rising edge, so no input changes at an edge.

// File: rtl/rfsh_pkg.sv
`timescale 1ns/1ps
// Shared types for the rank refresh sequencer.
package rfsh_pkg;
    typedef enum logic [2:0] {
        RF_IDLE      = 3'd0,
        RF_DRAIN     = 3'd1,
        RF_PD_EXIT   = 3'd2,
        RF_SREF_EXIT = 3'd3,
        RF_PRE       = 3'd4,
        RF_START     = 3'd5,
        RF_RUN       = 3'd6
    } rf_state_e;
endpackage

// File: rtl/rfsh_timer.sv
`timescale 1ns/1ps
// Time base and refresh shot timer.
// Counts cycles since reset and raises fire while armed and the count has
// reached the programmed shot time. Assumes the count never wraps in use.
module rfsh_timer #(
    parameter int TIME_W = 32,
    parameter int T_REFI = 7800,
    parameter int T_RP   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disarm,
    input  logic              rearm,
    input  logic [TIME_W-1:0] rearm_at,
    output logic [TIME_W-1:0] now,
    output logic              fire
);
    localparam logic [TIME_W-1:0] FIRST_AT = TIME_W'(T_REFI - T_RP);

    logic [TIME_W-1:0] fire_at;
    logic              armed;

    // Free-running cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end

    // Shot time and arm flag; re-arming wins over disarming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_at <= FIRST_AT;
            armed   <= 1'b1;
        end else if (rearm) begin
            fire_at <= rearm_at;
            armed   <= 1'b1;
        end else if (disarm) begin
            armed   <= 1'b0;
        end
    end

    // Shot condition.
    assign fire = armed && (now >= fire_at);
endmodule

// File: rtl/rfsh_due.sv
`timescale 1ns/1ps
// Absolute due-time keeper and overrun detector.
// capture loads the current time, advance moves the due time forward by one
// interval and checks that the refresh can still finish before it.
module rfsh_due #(
    parameter int TIME_W = 32,
    parameter int T_REFI = 7800,
    parameter int T_RFC  = 350
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              advance,
    input  logic [TIME_W-1:0] now,
    output logic [TIME_W-1:0] due,
    output logic              overrun
);
    logic [TIME_W-1:0] due_next;
    logic [TIME_W-1:0] done_at;

    // Advanced due time and completion time of a refresh issued now.
    assign due_next = due + TIME_W'(T_REFI);
    assign done_at  = now + TIME_W'(T_RFC);

    // Due-time register.
    always_ff @(posedge clk) begin
        if (!rst_n)       due <= '0;
        else if (capture) due <= now;
        else if (advance) due <= due_next;
    end

    // Sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                             overrun <= 1'b0;
        else if (advance && (due_next < done_at)) overrun <= 1'b1;
    end

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R7
endmodule

// File: rtl/rfsh_fsm.sv
`timescale 1ns/1ps
// Refresh sequence controller.
// Steps through drain wait, power-down exit, precharge, refresh issue and
// recovery, plus the recovery wait after self-refresh exit. Assumes banks
// stay closed from the start of the refresh until it completes.
module rfsh_fsm
    import rfsh_pkg::*;
#(
    parameter int BANK_W = 4,
    parameter int T_RFC  = 350,
    parameter int T_XP   = 6,
    parameter int T_XS   = 360
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              drain_done,
    input  logic [BANK_W-1:0] banks_open,
    input  logic              act_pending,
    input  logic              pwr_idle,
    input  logic              pwr_low,
    input  logic              wake_ack,
    input  logic              sref_entering,
    input  logic              sref_exit,
    input  logic              sys_drain,
    output logic              capture,
    output logic              disarm,
    output logic              rearm,
    output logic              pre_all,
    output logic              ref_cmd,
    output logic              rank_avail,
    output logic              ref_pending,
    output logic              wake_req,
    output logic              relow_req
);
    localparam int MAX_A = (T_RFC > T_XS) ? T_RFC : T_XS;
    localparam int MAX_D = (MAX_A > T_XP) ? MAX_A : T_XP;
    localparam int CNT_W = $clog2(MAX_D + 1);

    rf_state_e         state;
    logic [CNT_W-1:0]  wcnt;
    logic              was_low;
    logic              pre_done;
    logic              run_end;
    logic              banks_quiet;

    // Decoded outputs and handshakes to the timer and due keeper.
    assign banks_quiet = (banks_open == '0) && pwr_idle && !act_pending;
    assign pre_all     = (state == RF_PRE) && (banks_open != '0) && !pre_done;
    assign ref_cmd     = (state == RF_START) && (wcnt == '0);
    assign run_end     = (state == RF_RUN) && (wcnt == '0);
    assign rank_avail  = (state == RF_IDLE);
    assign ref_pending = (state != RF_IDLE) && (state != RF_SREF_EXIT);
    assign wake_req    = (state == RF_PD_EXIT) && pwr_low && !wake_ack;
    assign relow_req   = run_end && was_low && !sys_drain;
    assign rearm       = run_end && !sref_entering;
    assign disarm      = (state == RF_IDLE) && (fire || sref_exit);
    assign capture     = ((state == RF_IDLE) && fire && !sref_exit) ||
                         ((state == RF_SREF_EXIT) && (wcnt == '0));

    // Sequence state, wait counter and per-refresh flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RF_IDLE;
            wcnt     <= '0;
            was_low  <= 1'b0;
            pre_done <= 1'b0;
        end else begin
            case (state)
                RF_IDLE: begin
                    if (sref_exit) begin
                        state <= RF_SREF_EXIT;
                        wcnt  <= CNT_W'(T_XS - 1);
                    end else if (fire) begin
                        state   <= RF_DRAIN;
                        was_low <= 1'b0;
                    end
                end
                RF_SREF_EXIT: begin
                    if (wcnt == '0) begin
                        state   <= RF_DRAIN;
                        was_low <= 1'b0;
                    end else begin
                        wcnt <= wcnt - 1'b1;
                    end
                end
                RF_DRAIN: begin
                    if (drain_done) state <= RF_PD_EXIT;
                end
                RF_PD_EXIT: begin
                    if (pwr_low) was_low <= 1'b1;
                    if (!pwr_low || wake_ack) state <= RF_PRE;
                end
                RF_PRE: begin
                    if (pre_all) pre_done <= 1'b1;
                    if (banks_quiet) begin
                        state    <= RF_START;
                        pre_done <= 1'b0;
                        wcnt     <= was_low ? CNT_W'(T_XP) : '0;
                    end
                end
                RF_START: begin
                    if (wcnt == '0) begin
                        state <= RF_RUN;
                        wcnt  <= CNT_W'(T_RFC - 1);
                    end else begin
                        wcnt <= wcnt - 1'b1;
                    end
                end
                RF_RUN: begin
                    if (wcnt == '0) begin
                        state   <= RF_IDLE;
                        was_low <= 1'b0;
                    end else begin
                        wcnt <= wcnt - 1'b1;
                    end
                end
                default: state <= RF_IDLE;
            endcase
        end
    end

    AST_REF_BANKS_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |-> (banks_open == '0)); // R5
    AST_PRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all |=> !pre_all); // R5
    AST_REF_UNAVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |-> (!rank_avail && ref_pending)); // R3
    AST_REF_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |=> (!ref_cmd && !rank_avail)); // R8
    AST_WAKE_IN_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (ref_pending && !ref_cmd)); // R6
    AST_PEND_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_pending) |-> !rank_avail); // R2
endmodule

// File: rtl/rfsh_seq.sv
`timescale 1ns/1ps
// Per-rank refresh sequencer top.
// Joins the time base, the due-time keeper and the sequence controller.
// The next shot is placed one precharge time before the advanced due time.
module rfsh_seq #(
    parameter int TIME_W = 32,
    parameter int BANK_W = 4,
    parameter int T_REFI = 7800,
    parameter int T_RFC  = 350,
    parameter int T_RP   = 14,
    parameter int T_XP   = 6,
    parameter int T_XS   = 360
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drain_done,
    input  logic [BANK_W-1:0] banks_open,
    input  logic              act_pending,
    input  logic              pwr_idle,
    input  logic              pwr_low,
    input  logic              wake_ack,
    input  logic              sref_entering,
    input  logic              sref_exit,
    input  logic              in_sref,
    input  logic              sys_drain,
    output logic              pre_all,
    output logic              ref_cmd,
    output logic              rank_avail,
    output logic              ref_pending,
    output logic              wake_req,
    output logic              relow_req,
    output logic              sref_wake,
    output logic              overrun
);
    logic [TIME_W-1:0] now;
    logic [TIME_W-1:0] due;
    logic [TIME_W-1:0] rearm_at;
    logic              fire;
    logic              capture;
    logic              disarm;
    logic              rearm;

    // Next shot time with precharge compensation.
    assign rearm_at  = due - TIME_W'(T_RP);
    // Drain forces a self-refreshing rank awake.
    assign sref_wake = sys_drain && in_sref;

    rfsh_timer #(.TIME_W(TIME_W), .T_REFI(T_REFI), .T_RP(T_RP)) u_timer (
        .clk(clk), .rst_n(rst_n), .disarm(disarm), .rearm(rearm),
        .rearm_at(rearm_at), .now(now), .fire(fire)
    );

    rfsh_due #(.TIME_W(TIME_W), .T_REFI(T_REFI), .T_RFC(T_RFC)) u_due (
        .clk(clk), .rst_n(rst_n), .capture(capture), .advance(ref_cmd),
        .now(now), .due(due), .overrun(overrun)
    );

    rfsh_fsm #(.BANK_W(BANK_W), .T_RFC(T_RFC), .T_XP(T_XP), .T_XS(T_XS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .fire(fire), .drain_done(drain_done),
        .banks_open(banks_open), .act_pending(act_pending), .pwr_idle(pwr_idle),
        .pwr_low(pwr_low), .wake_ack(wake_ack), .sref_entering(sref_entering),
        .sref_exit(sref_exit), .sys_drain(sys_drain), .capture(capture),
        .disarm(disarm), .rearm(rearm), .pre_all(pre_all), .ref_cmd(ref_cmd),
        .rank_avail(rank_avail), .ref_pending(ref_pending), .wake_req(wake_req),
        .relow_req(relow_req)
    );

    AST_SREF_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_drain && in_sref) |-> sref_wake); // R12
endmodule

// File: tb/rfsh_seq_tb.sv
`timescale 1ns/1ps
// Self-checking bench for the rank refresh sequencer.
module rfsh_seq_tb;
    localparam int TIME_W = 32;
    localparam int BANK_W = 4;
    localparam int T_REFI = 40;
    localparam int T_RFC  = 8;
    localparam int T_RP   = 3;
    localparam int T_XP   = 2;
    localparam int T_XS   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drain_done = 1'b1;
    logic [BANK_W-1:0] banks_open = '0;
    logic act_pending = 1'b0;
    logic pwr_idle = 1'b1;
    logic pwr_low = 1'b0;
    logic wake_ack = 1'b0;
    logic sref_entering = 1'b0;
    logic sref_exit = 1'b0;
    logic in_sref = 1'b0;
    logic sys_drain = 1'b0;
    logic pre_all, ref_cmd, rank_avail, ref_pending;
    logic wake_req, relow_req, sref_wake, overrun;

    int n_chk = 0;
    int n_bad = 0;
    longint cyc = 0;
    int ref_cnt = 0;
    int pre_cnt = 0;
    int relow_cnt = 0;
    longint last_ref = 0;
    longint last_relow = 0;

    always #10 clk = ~clk;

    rfsh_seq #(.TIME_W(TIME_W), .BANK_W(BANK_W), .T_REFI(T_REFI), .T_RFC(T_RFC),
               .T_RP(T_RP), .T_XP(T_XP), .T_XS(T_XS)) u_dut (
        .clk(clk), .rst_n(rst_n), .drain_done(drain_done), .banks_open(banks_open),
        .act_pending(act_pending), .pwr_idle(pwr_idle), .pwr_low(pwr_low),
        .wake_ack(wake_ack), .sref_entering(sref_entering), .sref_exit(sref_exit),
        .in_sref(in_sref), .sys_drain(sys_drain), .pre_all(pre_all),
        .ref_cmd(ref_cmd), .rank_avail(rank_avail), .ref_pending(ref_pending),
        .wake_req(wake_req), .relow_req(relow_req), .sref_wake(sref_wake),
        .overrun(overrun)
    );

    // Cycle count matching the design's time base.
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // Output monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ref_cmd)   begin ref_cnt++;   last_ref = cyc;   end
            if (pre_all)   pre_cnt++;
            if (relow_req) begin relow_cnt++; last_relow = cyc; end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance to a quarter period after the next rising edge.
    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic wait_ref(input int target);
        for (int i = 0; i < 3000 && ref_cnt < target; i++) step();
    endtask

    task automatic wait_pend_rise(output longint p);
        for (int i = 0; i < 3000 && ref_pending; i++) step();
        for (int i = 0; i < 3000 && !ref_pending; i++) step();
        p = cyc;
    endtask

    task automatic pd_refresh(input int nref, output longint d);
        for (int i = 0; i < 3000 && !wake_req; i++) step();
        chk(wake_req == 1'b1, "R6 wake_req", wake_req, 1);
        step(); step();
        wake_ack = 1'b1;
        pwr_low  = 1'b0;
        d = cyc;
        step();
        wake_ack = 1'b0;
        wait_ref(nref);
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        longint p, d, p2;
        int c0;
        bit exp_ov;
        repeat (3) step();
        // R1 reset state
        chk(rank_avail == 1'b1 && ref_pending == 1'b0 && pre_all == 1'b0 &&
            ref_cmd == 1'b0 && wake_req == 1'b0 && relow_req == 1'b0 &&
            overrun == 1'b0, "R1 reset outputs", {rank_avail, ref_pending, overrun}, 3'b100);
        rst_n = 1'b1;

        // R1/R2 first refresh: shot at 37, pending at 38, REF at 41
        wait_ref(1);
        chk(last_ref == T_REFI - T_RP + 4, "R1 first refresh time", last_ref, T_REFI - T_RP + 4);
        for (int i = 0; i < 100 && !rank_avail; i++) step();
        chk(cyc == last_ref + T_RFC + 1, "R8 availability after refresh", cyc, last_ref + T_RFC + 1);
        wait_ref(2);
        chk(last_ref == 2 * (T_REFI - T_RP) + 4, "R2 second refresh time", last_ref, 2 * (T_REFI - T_RP) + 4);

        // R4 / R7 boundary: drain held, refresh lands exactly on the limit
        drain_done = 1'b0;
        wait_pend_rise(p);
        chk(p == last_ref - 3 + (T_REFI - T_RP), "R2 next shot placement", p, last_ref - 3 + (T_REFI - T_RP));
        chk(rank_avail == 1'b0, "R3 unavailable while pending", rank_avail, 0);
        c0 = ref_cnt;
        repeat (28) step();
        chk(ref_cnt == c0, "R4 no refresh while draining", ref_cnt, c0);
        drain_done = 1'b1;
        d = cyc;
        wait_ref(3);
        chk(last_ref == d + 3, "R4 refresh after drain", last_ref, d + 3);
        step();
        exp_ov = ((p - 1) + T_REFI) < (last_ref + T_RFC);
        chk(overrun == exp_ov, "R7 overrun at limit", overrun, exp_ov);

        // R7 one cycle past the limit
        drain_done = 1'b0;
        wait_pend_rise(p);
        repeat (29) step();
        drain_done = 1'b1;
        wait_ref(4);
        step();
        exp_ov = ((p - 1) + T_REFI) < (last_ref + T_RFC);
        chk(overrun == exp_ov && exp_ov, "R7 overrun past limit", overrun, 1);

        // R5 single precharge-all and quiet gating
        banks_open = 4'd2;
        pwr_idle = 1'b0;
        c0 = pre_cnt;
        wait_pend_rise(p);
        repeat (8) step();
        chk(pre_cnt == c0 + 1, "R5 one precharge-all", pre_cnt, c0 + 1);
        chk(ref_cnt == 4, "R5 refresh held with banks open", ref_cnt, 4);
        banks_open = '0;
        pwr_idle = 1'b1;
        act_pending = 1'b1;
        repeat (3) step();
        chk(ref_cnt == 4, "R5 refresh held by activate", ref_cnt, 4);
        act_pending = 1'b0;
        d = cyc;
        wait_ref(5);
        chk(last_ref == d + 1, "R5 refresh once quiet", last_ref, d + 1);
        chk(overrun == 1'b1, "R7 overrun sticky", overrun, 1);

        // R6 / R9 power-down exit with return to low power
        pwr_low = 1'b1;
        pd_refresh(6, d);
        chk(last_ref == d + 2 + T_XP, "R6 refresh delayed by exit time", last_ref, d + 2 + T_XP);
        repeat (T_RFC + 2) step();
        chk(relow_cnt == 1, "R9 low-power return pulse", relow_cnt, 1);
        chk(last_relow == last_ref + T_RFC, "R9 low-power return timing", last_relow, last_ref + T_RFC);

        // R9 / R12 drain suppresses the return to low power
        sys_drain = 1'b1;
        in_sref = 1'b1;
        #1;
        chk(sref_wake == 1'b1, "R12 self-refresh wake on drain", sref_wake, 1);
        in_sref = 1'b0;
        #1;
        chk(sref_wake == 1'b0, "R12 no wake outside self-refresh", sref_wake, 0);
        pwr_low = 1'b1;
        pd_refresh(7, d);
        repeat (T_RFC + 2) step();
        chk(relow_cnt == 1, "R9 no return under drain", relow_cnt, 1);
        sys_drain = 1'b0;
        #1;
        chk(sref_wake == 1'b0, "R12 wake released", sref_wake, 0);

        // R10 entering self-refresh stops re-arming
        sref_entering = 1'b1;
        wait_ref(8);
        repeat (T_RFC + 2) step();
        sref_entering = 1'b0;
        c0 = 0;
        for (int i = 0; i < 100; i++) begin
            step();
            if (ref_pending || !rank_avail) c0++;
        end
        chk(c0 == 0, "R10 no refresh after self-refresh entry", c0, 0);

        // R11 self-refresh exit recovery then refresh
        sref_exit = 1'b1;
        d = cyc;
        step();
        sref_exit = 1'b0;
        chk(rank_avail == 1'b0 && ref_pending == 1'b0, "R11 held during exit recovery",
            {rank_avail, ref_pending}, 0);
        chk(rank_avail == 1'b0, "R3 unavailable in exit recovery", rank_avail, 0);
        for (int i = 0; i < 100 && !ref_pending; i++) step();
        chk(cyc == d + 1 + T_XS, "R11 refresh start after exit", cyc, d + 1 + T_XS);
        p = cyc;
        wait_ref(9);
        chk(last_ref == p + 3, "R11 refresh issued", last_ref, p + 3);
        wait_pend_rise(p2);
        chk(p2 == p + (T_REFI - T_RP), "R2 re-armed after exit refresh", p2, p + (T_REFI - T_RP));

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule